// File: doc/BRIEF.md
# Platform Identification and Control Registers

This block is a small register decoder that sits behind an I/O access port. It answers two address windows. The fixed window covers 16 bytes and is decoded on the low four address bits. The relocatable window covers 256 bytes and is decoded on all eight address bits. Software uses the block for four things:

- reading an identification word, whose byte order reveals whether the guest driver has been refused;
- reading a version byte;
- recording a 16-bit driver product version;
- switching the option-ROM area between read-only and read-write.

A change to the ROM attribute is not applied locally. The block asks an external memory-attribute controller to make the change, over a request/acknowledge handshake. The local ROM-lock flag takes the new value only when that controller acknowledges without an error.

Register accesses arrive on a valid/ready request channel. While an attribute request is outstanding, `req_ready` stays low, so the requester is back-pressured and only one attribute change is ever in flight. Every accepted access produces a one-cycle response pulse. There is no response ready, so the consumer must take the response in that cycle.

Bytes written to the log port are forwarded on a one-cycle strobe to a separate log block. A restore input replays a saved flag value through the same handshake. Leaving reset counts as a flag write of 0.

Top module: `plat_id_regs`

## Requirements
- R1: A word read (size code 1) in the fixed window at offset 0 returns 0x49D2, or 0xD249 while `blacklist_i` is 1. A word read at any other fixed offset returns 0xFFFF.
- R2: A byte read (size code 0) in the fixed window returns the ROM-lock flag in bit 0 at offset 0, and 0x01 at offset 2. It returns 0xFF at every other offset. A dword read (size code 2) in the fixed window returns 0xFFFFFFFF.
- R3: A byte write at offset 0, in either window, raises `attr_req_valid` with `attr_req_ro` equal to bit 0 of the data, page 0xC0 and length 0x40. The request is held steady until `attr_ack`.
- R4: On an acknowledge with `attr_err` low, `rom_lock` takes the requested value. On an acknowledge with `attr_err` high, `rom_lock` keeps its old value.
- R5: While an attribute request is outstanding, `req_ready` is low and no access is accepted.
- R6: A word write to fixed offset 2 loads `drv_version`. A word write to fixed offset 0 and any dword write change neither `drv_version` nor `rom_lock`.
- R7: In the relocatable window (`req_win`=1), a byte read at offset 0 returns the flag. Every other read returns all ones for the access width.
- R8: A byte write to relocatable offset 8, or to fixed offset 2, pulses `log_valid` with the byte on `log_data`. A byte write to any other relocatable offset except 0 has no effect.
- R9: After reset, `rom_lock` is 0 and a read-write attribute request (`attr_req_ro`=0) is outstanding, with `req_ready` low.
- R10: `restore_valid` while idle starts a flag write of `restore_flag` through the same handshake. It produces no response.
- R11: A response for an access that is not a flag write pulses `rsp_valid` one cycle after acceptance. A flag write's response comes one cycle after its acknowledge. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high with valid |
| req_win | input | 1 | 0 fixed window, 1 relocatable window |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_addr | input | 8 | Offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, zero-extended |
| blacklist_i | input | 1 | Driver refused indication |
| restore_valid | input | 1 | Replay a saved flag value |
| restore_flag | input | 1 | Saved flag value |
| attr_req_valid | output | 1 | Attribute change request |
| attr_req_ro | output | 1 | 1 read-only, 0 read-write |
| attr_req_page | output | 8 | First page of ROM area |
| attr_req_len | output | 8 | Page count of ROM area |
| attr_ack | input | 1 | Attribute controller done |
| attr_err | input | 1 | Attribute change failed, valid with ack |
| log_valid | output | 1 | Log byte strobe |
| log_data | output | 8 | Log byte |
| rom_lock | output | 1 | Committed ROM-lock flag |
| drv_version | output | 16 | Driver product version |

## Verification
Every response that is not a flag write is due exactly one cycle after the edge that accepts it. The driver notes the cycle count when it hands over a request. The monitor compares the cycle at which each response appears against that count plus one. A flag write finishes only one cycle after the acknowledge, whose delay the bench's attribute responder sets, so for those the scoreboard checks the data and order but not the cycle. The flag, version and log strobe are checked on the falling edge after the completing cycle, which is when the registered outputs have settled.

// File: rtl/plat_pkg.sv
package plat_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  localparam logic [15:0] ID_MAGIC   = 16'h49D2;
  localparam logic [7:0]  ID_VERSION = 8'h01;
  localparam logic [7:0]  ROM_PAGE   = 8'hC0;
  localparam logic [7:0]  ROM_PAGES  = 8'h40;

  typedef struct packed {
    logic              flag_wr;
    logic              ver_wr;
    logic              log_wr;
    logic [DATA_W-1:0] rdata;
  } dec_t;
endpackage

// File: rtl/plat_decode.sv
module plat_decode
  import plat_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int FIX_SPAN = 16,
  parameter int ALT_OFF  = 2,
  parameter int LOG_OFF  = 8
) (
  input  logic              win,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blacklist,
  input  logic              flag,
  output dec_t              dec
);
  localparam int FIX_AW = $clog2(FIX_SPAN);

  logic [FIX_AW-1:0] foff;
  logic              fix0, fix_alt, rel0, rel_log;
  logic [DATA_W-1:0] all_ones;

  assign foff    = addr[FIX_AW-1:0];
  assign fix0    = !win && (foff == '0);
  assign fix_alt = !win && (foff == FIX_AW'(ALT_OFF));
  assign rel0    = win && (addr == '0);
  assign rel_log = win && (addr == ADDR_W'(LOG_OFF));

  always_comb begin
    case (size)
      SZ_BYTE: all_ones = DATA_W'(8'hFF);
      SZ_WORD: all_ones = DATA_W'(16'hFFFF);
      default: all_ones = '1;
    endcase
  end

  always_comb begin
    dec         = '0;
    dec.flag_wr = wr && (size == SZ_BYTE) && (fix0 || rel0);
    dec.ver_wr  = wr && (size == SZ_WORD) && fix_alt;
    dec.log_wr  = wr && (size == SZ_BYTE) && (fix_alt || rel_log);
    if (!wr) begin
      dec.rdata = all_ones;
      if (size == SZ_WORD && fix0)
        dec.rdata = blacklist ? DATA_W'({ID_MAGIC[7:0], ID_MAGIC[15:8]})
                              : DATA_W'(ID_MAGIC);
      else if (size == SZ_BYTE && (fix0 || rel0))
        dec.rdata = DATA_W'(flag);
      else if (size == SZ_BYTE && fix_alt)
        dec.rdata = DATA_W'(ID_VERSION);
    end
  end
endmodule

// File: rtl/plat_attr_ctl.sv
module plat_attr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_val,
  input  logic attr_ack,
  input  logic attr_err,
  output logic busy,
  output logic done,
  output logic req_ro,
  output logic flag
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      pend <= 1'b0;
      flag <= 1'b0;
    end else if (busy && attr_ack) begin
      busy <= 1'b0;
      if (!attr_err) flag <= pend;
    end else if (!busy && start) begin
      busy <= 1'b1;
      pend <= start_val;
    end
  end

  assign done   = busy && attr_ack;
  assign req_ro = pend;

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !attr_ack |=> busy && $stable(req_ro));
  a_r4_keep_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    busy && attr_ack && attr_err |=> $stable(flag));
  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
    busy && attr_ack && !attr_err |=> flag == $past(req_ro));
endmodule

// File: rtl/plat_id_regs.sv
module plat_id_regs
  import plat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_win,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              blacklist_i,
  input  logic              restore_valid,
  input  logic              restore_flag,
  output logic              attr_req_valid,
  output logic              attr_req_ro,
  output logic [7:0]        attr_req_page,
  output logic [7:0]        attr_req_len,
  input  logic              attr_ack,
  input  logic              attr_err,
  output logic              log_valid,
  output logic [7:0]        log_data,
  output logic              rom_lock,
  output logic [VER_W-1:0]  drv_version
);
  dec_t dec;
  logic busy, done, accept, take_rst, start, start_val, rsp_owed;

  plat_decode #(.ADDR_W(ADDR_W)) u_dec (
    .win(req_win), .wr(req_write), .size(req_size), .addr(req_addr),
    .blacklist(blacklist_i), .flag(rom_lock), .dec(dec)
  );

  assign req_ready = !busy && !restore_valid;
  assign accept    = req_valid && req_ready;
  assign take_rst  = restore_valid && !busy;
  assign start     = take_rst || (accept && dec.flag_wr);
  assign start_val = take_rst ? restore_flag : req_wdata[0];

  plat_attr_ctl u_attr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_val(start_val),
    .attr_ack(attr_ack), .attr_err(attr_err), .busy(busy), .done(done),
    .req_ro(attr_req_ro), .flag(rom_lock)
  );

  assign attr_req_valid = busy;
  assign attr_req_page  = ROM_PAGE;
  assign attr_req_len   = ROM_PAGES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_owed    <= 1'b0;
      log_valid   <= 1'b0;
      log_data    <= '0;
      drv_version <= '0;
    end else begin
      rsp_valid <= (accept && !dec.flag_wr) || (done && rsp_owed);
      rsp_rdata <= accept ? dec.rdata : '0;
      if (accept && dec.flag_wr) rsp_owed <= 1'b1;
      else if (done)             rsp_owed <= 1'b0;
      log_valid <= accept && dec.log_wr;
      if (accept && dec.log_wr) log_data <= req_wdata[7:0];
      if (accept && dec.ver_wr) drv_version <= req_wdata[VER_W-1:0];
    end
  end

  a_r5_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    attr_req_valid |-> !req_ready);
  a_r11_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !(req_write && req_size == SZ_BYTE && req_addr == '0)
    |=> rsp_valid);
  a_r11_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> rsp_rdata == '0);
  a_r8_log_once: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> $past(req_valid && req_ready && req_write));
endmodule

// File: tb/plat_id_regs_tb.sv
module plat_id_regs_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_win = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  logic rsp_valid, blacklist_i = 0, restore_valid = 0, restore_flag = 0;
  logic attr_req_valid, attr_req_ro, attr_ack = 0, attr_err = 0;
  logic [7:0] attr_req_page, attr_req_len, log_data;
  logic log_valid, rom_lock;
  logic [15:0] drv_version;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, nxt_err = 0;
  logic [31:0] exp_data[$];
  int exp_cyc[$];
  logic [7:0] log_q[$];
  logic attr_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  plat_id_regs u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // attribute controller model
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      attr_ack = 0;
      if (rst_n && attr_req_valid) begin
        cnt++;
        if (cnt >= 3) begin
          attr_ack = 1; attr_err = nxt_err; attr_q.push_back(attr_req_ro); cnt = 0;
        end
      end
    end
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (exp_data.size() == 0) chk(0, "R10 unexpected response", rsp_rdata, 0);
      else begin
        logic [31:0] e; int c;
        e = exp_data.pop_front(); c = exp_cyc.pop_front();
        chk(rsp_rdata == e, "R1/R2/R7 response data", rsp_rdata, e);
        if (c >= 0) chk(cyc == c, "R11 response cycle", cyc, c);
      end
    end
    if (log_valid) begin
      if (log_q.size() == 0) chk(0, "R8 unexpected log", log_data, 0);
      else begin
        logic [7:0] l; l = log_q.pop_front();
        chk(log_data == l, "R8 log byte", log_data, l);
      end
    end
  end

  task automatic access(input bit win, input bit wr, input logic [1:0] sz,
                        input logic [7:0] a, input logic [31:0] d, input logic [31:0] exp, input bit is_flag);
    @(negedge clk);
    req_valid = 1; req_win = win; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_data.push_back(exp);
    exp_cyc.push_back(is_flag ? -1 : cyc + 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (is_flag) chk(req_ready == 0, "R5 ready low while pending", req_ready, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (attr_req_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_attr(input logic exp, input string req);
    logic v;
    if (attr_q.size() == 0) chk(0, req, 0, exp);
    else begin v = attr_q.pop_front(); chk(v == exp, req, v, exp); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(attr_req_valid == 1, "R9 request after reset", attr_req_valid, 1);
    chk(attr_req_ro == 0, "R9 read-write request", attr_req_ro, 0);
    chk(req_ready == 0, "R9 ready low", req_ready, 0);
    chk(rom_lock == 0, "R9 flag clear", rom_lock, 0);
    chk(attr_req_page == 8'hC0, "R3 page", attr_req_page, 8'hC0);
    chk(attr_req_len == 8'h40, "R3 length", attr_req_len, 8'h40);
    wait_idle();
    chk_attr(0, "R9 reset request value");

    // R1
    access(0, 0, 1, 8'h00, 0, 32'h49D2, 0);
    blacklist_i = 1;
    access(0, 0, 1, 8'h00, 0, 32'hD249, 0);
    blacklist_i = 0;
    access(0, 0, 1, 8'h04, 0, 32'hFFFF, 0);
    // R2
    access(0, 0, 0, 8'h00, 0, 32'h0, 0);
    access(0, 0, 0, 8'h02, 0, 32'h1, 0);
    access(0, 0, 0, 8'h05, 0, 32'hFF, 0);
    access(0, 0, 2, 8'h00, 0, 32'hFFFFFFFF, 0);
    // R3 R4 commit
    access(0, 1, 0, 8'h00, 32'h01, 0, 1);
    wait_idle();
    chk_attr(1, "R3 read-only request");
    chk(rom_lock == 1, "R4 commit on success", rom_lock, 1);
    access(0, 0, 0, 8'h00, 0, 32'h1, 0);
    // R4 error keeps
    nxt_err = 1;
    access(0, 1, 0, 8'h00, 32'h00, 0, 1);
    wait_idle();
    nxt_err = 0;
    chk_attr(0, "R3 request value");
    chk(rom_lock == 1, "R4 keep on error", rom_lock, 1);
    // R6
    access(0, 1, 1, 8'h02, 32'h1234, 0, 0);
    @(negedge clk);
    chk(drv_version == 16'h1234, "R6 version write", drv_version, 16'h1234);
    access(0, 1, 1, 8'h00, 32'hBEEF, 0, 0);
    access(0, 1, 2, 8'h00, 32'hCAFE0000, 0, 0);
    access(0, 1, 2, 8'h02, 32'h5555, 0, 0);
    @(negedge clk);
    chk(drv_version == 16'h1234, "R6 ignored writes", drv_version, 16'h1234);
    chk(rom_lock == 1, "R6 flag untouched", rom_lock, 1);
    chk(attr_req_valid == 0, "R6 no attribute request", attr_req_valid, 0);
    // R7
    access(1, 0, 0, 8'h00, 0, 32'h1, 0);
    access(1, 0, 0, 8'h08, 0, 32'hFF, 0);
    access(1, 0, 1, 8'h00, 0, 32'hFFFF, 0);
    access(1, 0, 2, 8'h10, 0, 32'hFFFFFFFF, 0);
    // R8
    log_q.push_back(8'h41);
    access(1, 1, 0, 8'h08, 32'h41, 0, 0);
    log_q.push_back(8'h42);
    access(0, 1, 0, 8'h02, 32'h42, 0, 0);
    access(1, 1, 0, 8'h04, 32'h00, 0, 0);
    repeat (2) @(negedge clk);
    chk(rom_lock == 1 && attr_req_valid == 0, "R8 other offset ignored", rom_lock, 1);
    chk(log_q.size() == 0, "R8 log drained", log_q.size(), 0);
    // R3 via relocatable window
    access(1, 1, 0, 8'h00, 32'h00, 0, 1);
    wait_idle();
    chk_attr(0, "R3 relocatable flag write");
    chk(rom_lock == 0, "R4 relocatable commit", rom_lock, 0);
    // R10
    @(negedge clk);
    restore_valid = 1; restore_flag = 1;
    @(negedge clk);
    restore_valid = 0;
    chk(attr_req_valid == 1 && attr_req_ro == 1, "R10 restore request", {attr_req_valid, attr_req_ro}, 2'b11);
    wait_idle();
    chk_attr(1, "R10 restore value");
    chk(rom_lock == 1, "R10 restore commit", rom_lock, 1);
    repeat (3) @(negedge clk);
    chk(exp_data.size() == 0, "R11 all responses seen", exp_data.size(), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule